// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel that moves 32-bit words between a device and memory. It has two buffer descriptors held in address registers. The active pair (`next`, `limit`) steps through the buffer in progress. The pending pair (`start`, `stop`) holds the buffer that comes after it. When the active buffer runs out and the chain flag is armed, the pending pair is copied into the active pair in one cycle. The next buffer then starts without any software action in the gap.

Software drives the channel through a 32-bit register port. A write to the control/status register is a command word: each bit sets or clears one piece of state. A read of the same register returns the live status. Each completed buffer sets a completion flag, and that flag drives a level interrupt. At that moment the block latches the finished segment's first address and the final value of `next`. Software subtracts one from the other to learn how many bytes moved. On a transmit channel, bit 31 of the limit marks end of packet. That bit plays no part in the address compare.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset all status bits read as zero, `irq` is low and no memory request is issued.
- R2: The address registers read back exactly as written. The register indices are: 1 next, 3 limit, 4 start, 5 stop, 6 saved-next, 7 saved-limit, 8 saved-start, 9 saved-stop. Index 2 is a second write path into `next`, and reading index 2 returns `next`.
- R3: Register index 0 is the command/status register. Command bits are: 0 set-enable, 1 set-chain, 2 clear-complete, 3 reset, 4 init-buffer (no effect), 5 set-read, 6 set-write. Status bits are: 0 enable, 1 chain, 2 complete, 3 bus-exception, 4 read-direction. The reset command clears enable, chain, complete and bus-exception. Set bits in the same word are then applied on top. Set-read alone makes the direction 1, set-write alone makes it 0, and both together leave it unchanged.
- R4: While enable is set, `devReady` is high and `next` differs from `limit`, the block raises `memReq` with `memAddr` equal to `next`. Each cycle with `memAck` high advances `next` by 4. With `devReady` low there is no request, and without `memAck` the address holds.
- R5: When `next` equals `limit` while chain is set, `start` and `stop` are copied into `next` and `limit`. In the same step chain clears, complete sets and enable stays set.
- R6: When `next` equals `limit` while chain is clear, enable clears and complete sets (shutdown).
- R7: `irq` is high exactly while complete is set; clear-complete drops it.
- R8: On each buffer switch and on shutdown, saved-next receives the finishing segment's first address and saved-limit receives its final `next`.
- R9: With the transmit option, bit 31 of `limit` is left out of the end-of-buffer compare. `memEop` is high on the request for the last word of a buffer whose limit has bit 31 set.
- R10: `busErr` sets bus-exception, clears enable and stops `next` from advancing on that cycle.
- R11: `memWrite` equals the read-direction status bit (device-to-memory writes memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Word transfer request |
| memAddr | output | 32 | Word address of the request |
| memWrite | output | 1 | Request writes memory |
| memEop | output | 1 | Last word of a packet-tagged buffer |
| memAck | input | 1 | Request accepted this cycle |
| devReady | input | 1 | Device can source or sink a word |
| busErr | input | 1 | Bus error on the memory side |
| irq | output | 1 | Level interrupt, follows complete |

## Verification
The bench runs every combination of first-segment and second-segment length in a small range, in both directions. For each run it predicts the exact word address sequence across the buffer switch. A design that reloaded late, or skipped the reload, would show a gap or a wrong address at the seam. Capturing the saved pair one segment off would give a wrong length.

It sweeps all 128 command words after a reset command. This catches wrong precedence between reset and set bits, and the wrong handling of both direction bits at once. A packet-tagged limit checks that bit 31 cannot stop the compare from matching, which would otherwise make the channel run away. A bus error placed after two acknowledged words checks that `next` freezes at exactly two words in.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] REG_CSR         = 4'd0;
  localparam logic [REG_IDX_W-1:0] REG_NEXT        = 4'd1;
  localparam logic [REG_IDX_W-1:0] REG_NEXT_INIT   = 4'd2;
  localparam logic [REG_IDX_W-1:0] REG_LIMIT       = 4'd3;
  localparam logic [REG_IDX_W-1:0] REG_START       = 4'd4;
  localparam logic [REG_IDX_W-1:0] REG_STOP        = 4'd5;
  localparam logic [REG_IDX_W-1:0] REG_SAVED_NEXT  = 4'd6;
  localparam logic [REG_IDX_W-1:0] REG_SAVED_LIMIT = 4'd7;
  localparam logic [REG_IDX_W-1:0] REG_SAVED_START = 4'd8;
  localparam logic [REG_IDX_W-1:0] REG_SAVED_STOP  = 4'd9;

  // command bit positions
  localparam int CMD_SET_EN    = 0;
  localparam int CMD_SET_CHAIN = 1;
  localparam int CMD_CLR_CPL   = 2;
  localparam int CMD_RESET     = 3;
  localparam int CMD_INIT_BUF  = 4;
  localparam int CMD_SET_READ  = 5;
  localparam int CMD_SET_WRITE = 6;
  localparam int CMD_W         = 7;

  // status bit positions
  localparam int ST_EN    = 0;
  localparam int ST_CHAIN = 1;
  localparam int ST_CPL   = 2;
  localparam int ST_BEXC  = 3;
  localparam int ST_READ  = 4;
  localparam int ST_W     = 5;

  typedef struct packed {
    logic advance;
    logic loadCont;
    logic captureSaved;
  } dpStrobe_t;
endpackage

// File: rtl/dma_chain_datapath.sv
module dma_chain_datapath
  import dma_chain_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit TX_EOP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  dpStrobe_t            strobe,
  output logic [DATA_W-1:0]    nextAddr,
  output logic                 atLimit,
  output logic                 lastWord,
  output logic                 eopTag,
  output logic [DATA_W-1:0]    addrRdata
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);
  localparam logic [DATA_W-1:0] CMP_MASK =
      TX_EOP ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};

  logic [DATA_W-1:0] nextR, limitR, startR, stopR, segStart;
  logic [DATA_W-1:0] savedNext, savedLimit, savedStart, savedStop;

  assign nextAddr = nextR;
  assign atLimit  = (nextR & CMP_MASK) == (limitR & CMP_MASK);
  assign lastWord = ((nextR + STEP) & CMP_MASK) == (limitR & CMP_MASK);
  assign eopTag   = TX_EOP && limitR[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextR <= '0; limitR <= '0; startR <= '0; stopR <= '0; segStart <= '0;
      savedNext <= '0; savedLimit <= '0; savedStart <= '0; savedStop <= '0;
    end else begin
      if (strobe.captureSaved) begin
        savedNext  <= segStart;
        savedLimit <= nextR;
      end
      if (strobe.loadCont) begin
        nextR    <= startR;
        limitR   <= stopR;
        segStart <= startR;
      end else if (strobe.advance) begin
        nextR <= nextR + STEP;
      end
      if (regWe) begin
        case (regAddr)
          REG_NEXT, REG_NEXT_INIT: begin nextR <= regWdata; segStart <= regWdata; end
          REG_LIMIT:       limitR     <= regWdata;
          REG_START:       startR     <= regWdata;
          REG_STOP:        stopR      <= regWdata;
          REG_SAVED_NEXT:  savedNext  <= regWdata;
          REG_SAVED_LIMIT: savedLimit <= regWdata;
          REG_SAVED_START: savedStart <= regWdata;
          REG_SAVED_STOP:  savedStop  <= regWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_NEXT, REG_NEXT_INIT: addrRdata = nextR;
      REG_LIMIT:       addrRdata = limitR;
      REG_START:       addrRdata = startR;
      REG_STOP:        addrRdata = stopR;
      REG_SAVED_NEXT:  addrRdata = savedNext;
      REG_SAVED_LIMIT: addrRdata = savedLimit;
      REG_SAVED_START: addrRdata = savedStart;
      REG_SAVED_STOP:  addrRdata = savedStop;
      default:         addrRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chain_control.sv
module dma_chain_control
  import dma_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             atLimit,
  input  logic             devReady,
  input  logic             memAck,
  input  logic             busErr,
  output logic             memReq,
  output dpStrobe_t        strobe,
  output logic [ST_W-1:0]  status
);
  logic enR, chainR, cplR, bexcR, readR;
  logic endEvt;

  assign memReq = enR && !atLimit && devReady;
  assign endEvt = enR && atLimit && !busErr;

  assign strobe.advance      = memReq && memAck && !busErr;
  assign strobe.loadCont     = endEvt && chainR;
  assign strobe.captureSaved = endEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enR <= 1'b0; chainR <= 1'b0; cplR <= 1'b0; bexcR <= 1'b0; readR <= 1'b0;
    end else begin
      if (busErr) begin
        bexcR <= 1'b1;
        enR   <= 1'b0;
      end else if (endEvt) begin
        cplR <= 1'b1;
        if (chainR) chainR <= 1'b0;
        else        enR    <= 1'b0;
      end
      if (cmdWe) begin
        if (cmdWord[CMD_RESET]) begin
          enR <= 1'b0; chainR <= 1'b0; cplR <= 1'b0; bexcR <= 1'b0;
        end
        if (cmdWord[CMD_CLR_CPL]) cplR <= 1'b0;
        if (cmdWord[CMD_SET_READ] && !cmdWord[CMD_SET_WRITE]) readR <= 1'b1;
        else if (cmdWord[CMD_SET_WRITE] && !cmdWord[CMD_SET_READ]) readR <= 1'b0;
        if (cmdWord[CMD_SET_EN])    enR    <= 1'b1;
        if (cmdWord[CMD_SET_CHAIN]) chainR <= 1'b1;
      end
    end
  end

  always_comb begin
    status           = '0;
    status[ST_EN]    = enR;
    status[ST_CHAIN] = chainR;
    status[ST_CPL]   = cplR;
    status[ST_BEXC]  = bexcR;
    status[ST_READ]  = readR;
  end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit TX_EOP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 memReq,
  output logic [DATA_W-1:0]    memAddr,
  output logic                 memWrite,
  output logic                 memEop,
  input  logic                 memAck,
  input  logic                 devReady,
  input  logic                 busErr,
  output logic                 irq
);
  dpStrobe_t         strobe;
  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] nextAddr, addrRdata;
  logic              atLimit, lastWord, eopTag;
  logic              stEn, stChain, stCpl, stBexc;

  dma_chain_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWe(regWe && regAddr == REG_CSR), .cmdWord(regWdata[CMD_W-1:0]),
    .atLimit(atLimit), .devReady(devReady), .memAck(memAck), .busErr(busErr),
    .memReq(memReq), .strobe(strobe), .status(status)
  );

  dma_chain_datapath #(.DATA_W(DATA_W), .TX_EOP(TX_EOP)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .nextAddr(nextAddr), .atLimit(atLimit), .lastWord(lastWord),
    .eopTag(eopTag), .addrRdata(addrRdata)
  );

  assign stEn     = status[ST_EN];
  assign stChain  = status[ST_CHAIN];
  assign stCpl    = status[ST_CPL];
  assign stBexc   = status[ST_BEXC];
  assign memAddr  = nextAddr;
  assign memWrite = status[ST_READ];
  assign memEop   = memReq && eopTag && lastWord;
  assign irq      = stCpl;
  assign regRdata = (regAddr == REG_CSR) ? DATA_W'(status) : addrRdata;
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              busErr,
  input logic              memReq,
  input logic              memAck,
  input logic              enable,
  input logic              chain,
  input logic              complete,
  input logic              busExc,
  input logic              atLimit,
  input logic [DATA_W-1:0] nextAddr
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  // R4
  advance_by_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !busErr && !regWe) |=> nextAddr == $past(nextAddr) + STEP);

  // R5
  chain_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && atLimit && chain && !busErr && !regWe) |=> (enable && !chain && complete));

  // R6
  shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && atLimit && !chain && !busErr && !regWe) |=> (!enable && complete));

  // R10
  bus_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !regWe) |=> (busExc && !enable));
endmodule

bind dma_chain_channel dma_chain_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .busErr(busErr), .memReq(memReq),
  .memAck(memAck), .enable(stEn), .chain(stChain), .complete(stCpl),
  .busExc(stBexc), .atLimit(atLimit), .nextAddr(nextAddr)
);

// File: tb/test_dma_chain_channel.sv
module test_dma_chain_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWrite, memEop, irq;
  logic [31:0] memAddr;
  logic        ackEn = 1'b0, devReady = 1'b0, busErr = 1'b0;
  logic        memAck;

  int nChecks = 0, nFail = 0;

  // monitor model
  logic        monOn = 1'b0, expWrite = 1'b0, expEop = 1'b0;
  logic [31:0] expAddr, endA, startB, endB;
  int          seg = 0, reqCnt = 0;

  assign memAck = ackEn & memReq;

  always #10 clk = ~clk;

  dma_chain_channel #(.DATA_W(32), .TX_EOP(1'b1)) i_dma_chain_channel (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memWrite(memWrite),
    .memEop(memEop), .memAck(memAck), .devReady(devReady), .busErr(busErr), .irq(irq)
  );

  localparam logic [31:0] C_EN = 32'h01, C_CH = 32'h02, C_CLR = 32'h04, C_RST = 32'h08,
                          C_INIT = 32'h10, C_RD = 32'h20, C_WR = 32'h40;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    @(negedge clk); d = regRdata;
    @(posedge clk); #1;
  endtask

  task automatic waitIrq();
    while (irq !== 1'b1) @(negedge clk);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (monOn && memReq && memAck) begin
      logic [31:0] curEnd;
      if (seg == 0 && expAddr == endA) begin expAddr = startB; seg = 1; end
      curEnd = (seg == 0) ? endA : endB;
      check("R4 address", memAddr, expAddr);
      check("R11 direction", {31'd0, memWrite}, {31'd0, expWrite});
      check("R9 eop", {31'd0, memEop}, {31'd0, expEop && (expAddr + 32'd4 == curEnd)});
      expAddr = expAddr + 32'd4;
      reqCnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    // R1
    regAddr = 4'd0;
    @(negedge clk);
    check("R1 status", regRdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 memReq", {31'd0, memReq}, 32'd0);
    @(posedge clk); #1;

    // R2 readback sweep
    for (int i = 1; i <= 9; i++) begin
      if (i == 2) continue;
      wr(4'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_1110));
    end
    for (int i = 1; i <= 9; i++) begin
      if (i == 2) continue;
      rd(4'(i), v);
      check("R2 readback", v, 32'hA500_0000 ^ (32'(i) * 32'h0101_1110));
    end
    wr(4'd2, 32'h0000_7770);
    rd(4'd1, v); check("R2 alias into next", v, 32'h0000_7770);
    rd(4'd2, v); check("R2 alias read", v, 32'h0000_7770);

    // R3 command sweep, no movement: next != limit, device idle
    wr(4'd1, 32'h100); wr(4'd3, 32'h200);
    devReady = 1'b0;
    begin
      logic dir;
      dir = 1'b0;
      for (int c = 0; c < 128; c++) begin
        logic [31:0] exp;
        wr(4'd0, C_RST);
        wr(4'd0, 32'(c));
        if (c[5] && !c[6]) dir = 1'b1;
        else if (c[6] && !c[5]) dir = 1'b0;
        exp = {27'd0, dir, 1'b0, 1'b0, c[1] ? 1'b1 : 1'b0, c[0] ? 1'b1 : 1'b0};
        rd(4'd0, v);
        check("R3 command word", v, exp);
      end
    end
    wr(4'd0, C_RST);

    // R5 R6 R7 R8 chained runs
    for (int nA = 1; nA <= 2; nA++) begin
      for (int nB = 2; nB <= 3; nB++) begin
        logic dirRead;
        logic [31:0] aBase, dirCmd;
        dirRead = ((nA + nB) % 2) == 1;
        dirCmd  = dirRead ? C_RD : C_WR;
        aBase   = 32'h0000_1000 + 32'(nA * 32'h100);
        expAddr = aBase; endA = aBase + 32'(16 * nA);
        startB  = 32'h0002_0000 + 32'(nB * 32'h40); endB = startB + 32'(16 * nB);
        seg = 0; reqCnt = 0; expWrite = dirRead; expEop = 1'b0;
        devReady = 1'b0; ackEn = 1'b0;
        wr(4'd0, 32'd0);
        wr(4'd0, C_RST | C_INIT | dirCmd);
        wr(dirRead ? 4'd2 : 4'd1, aBase);
        wr(4'd3, endA); wr(4'd4, startB); wr(4'd5, endB);
        devReady = 1'b1; ackEn = 1'b1; monOn = 1'b1;
        wr(4'd0, C_EN | C_CH | dirCmd);
        waitIrq();
        rd(4'd0, v);
        check("R5 status after switch", v & 32'h7, 32'h5);
        rd(4'd6, v); check("R8 saved first addr seg A", v, aBase);
        rd(4'd7, v); check("R8 saved final next seg A", v, endA);
        wr(4'd0, C_CLR | dirCmd);
        check("R7 irq drops on clear", {31'd0, irq}, 32'd0);
        waitIrq();
        check("R4 word count", 32'(reqCnt), 32'(4 * (nA + nB)));
        rd(4'd0, v);
        check("R6 status after shutdown", v, {27'd0, dirRead, 4'b0100});
        check("R7 irq follows complete", {31'd0, irq}, 32'd1);
        rd(4'd1, v); check("R5 next ran through stop", v, endB);
        rd(4'd6, v); check("R8 saved first addr seg B", v, startB);
        rd(4'd7, v); check("R8 saved final next seg B", v, endB);
        wr(4'd0, C_CLR | C_RST);
        check("R7 irq after clear", {31'd0, irq}, 32'd0);
        monOn = 1'b0;
      end
    end

    // R4 and R10: handshake stalls and bus error
    ackEn = 1'b0; devReady = 1'b1;
    wr(4'd0, C_RST);
    wr(4'd1, 32'h0000_4000); wr(4'd3, 32'h0000_4040);
    wr(4'd0, C_EN | C_WR);
    @(negedge clk);
    check("R4 request without ack", {31'd0, memReq}, 32'd1);
    check("R4 address held", memAddr, 32'h0000_4000);
    devReady = 1'b0;
    @(negedge clk);
    check("R4 no request when device idle", {31'd0, memReq}, 32'd0);
    @(posedge clk); #1;
    devReady = 1'b1; ackEn = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    busErr = 1'b1;
    @(posedge clk); #1;
    busErr = 1'b0; ackEn = 1'b0;
    rd(4'd0, v);
    check("R10 status after bus error", v & 32'hF, 32'h8);
    check("R10 no request after bus error", {31'd0, memReq}, 32'd0);
    rd(4'd1, v); check("R10 next frozen", v, 32'h0000_4008);
    wr(4'd0, C_RST);
    rd(4'd0, v); check("R3 reset clears bus exception", v & 32'hF, 32'h0);

    // R9 packet-tagged limit
    expAddr = 32'h0000_6000; endA = 32'h0000_6010; startB = 32'hFFFF_FFF0; endB = 32'd0;
    seg = 0; reqCnt = 0; expWrite = 1'b1; expEop = 1'b1;
    wr(4'd1, 32'h0000_6000); wr(4'd3, 32'h8000_6010);
    devReady = 1'b1; ackEn = 1'b1; monOn = 1'b1;
    wr(4'd0, C_EN | C_RD);
    waitIrq();
    check("R9 words with tagged limit", 32'(reqCnt), 32'd4);
    rd(4'd0, v); check("R9 shutdown at tagged limit", v & 32'h7, 32'h4);
    rd(4'd7, v); check("R9 saved final next", v, 32'h0000_6010);
    monOn = 1'b0;
    wr(4'd0, C_CLR | C_RST);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule